// File: doc/BRIEF.md
# Floppy Data-Rate and Precompensation Control Register

This block is the write-only rate control register of a floppy disk controller. A host writes one byte over a simple register bus. The byte carries three things. The first is a two-bit rate selector. The second is a three-bit write precompensation code. The last two are a request to enter manual low power and a software-reset request that clears itself. A read-only shadow copy of the held state is kept for the runtime register block.

The block turns the held rate selector into the MFM and FM bit rates for the attached drive. It also produces the density-select level and the decoded precompensation step count, taking the two-bit drive-type input into account. It gives a one-cycle software-reset pulse to the rest of the controller, and a low-power flag that the clock-gating and data-separator logic use to stop. That flag is cleared by a software reset or by the side effect of a host access to the data register or the main status register. Writing a 0 into the low-power bit does not clear it.

Top module: `fdc_rate_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the rate field becomes 2'b10 (250 Kbps MFM), the precompensation code becomes 3'b000, and `low_power` and `sw_rst` become 0. The shadow byte then reads 8'h02.
- R2: A write (`wr_en` high at a clock edge) loads `wr_data[1:0]` as the rate field and `wr_data[4:2]` as the precompensation code. After that edge the shadow reads {0, low_power, 0, code, rate}, so bit 5 and bit 7 always read 0.
- R3: A write with `wr_data[7]`=1 makes `sw_rst` high for exactly the one cycle that follows that edge. The rate and code fields take the written values and are not restored to their reset values.
- R4: A write with bit 7=0 and bit 6=1 sets `low_power` after the edge. A write with bit 6=0 leaves `low_power` unchanged.
- R5: `dat_acc` or `sts_acc` high at an edge clears `low_power`. This holds even when a write that sets the flag happens in the same cycle.
- R6: A write with bit 7=1 clears `low_power`, whatever the value of bit 6.
- R7: `mfm_rate` uses the codes 1=125K, 2=150K, 3=250K, 4=300K, 5=500K, 6=1M, 7=2M. With drive type 00 or 11, rate fields 11/00/01/10 give 6/5/4/3.
- R8: With rate field 01, drive type 01 gives `mfm_rate`=5 and drive type 10 gives `mfm_rate`=7. The other rate fields do not depend on drive type.
- R9: `fm_rate` uses the same codes, with 0 meaning no FM rate. Rate fields 00/01/10 give 3/2/1 and rate field 11 gives 0. Rate field 01 gives 3 with drive type 01 and 0 with drive type 10.
- R10: `density` is 1 for rate fields 11 and 00 and 0 for rate fields 01 and 10, for every drive type.
- R11: For codes 3'b001 to 3'b110, `precomp_units` equals the code and `precomp_dflt` is 0. Code 3'b111 gives 0 units with `precomp_dflt`=0. Code 3'b000 gives 0 units with `precomp_dflt`=1.
- R12: Without a write, the rate and code fields hold, including across data or status register accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Host write strobe for this register |
| wr_data | input | 8 | Host write byte |
| dat_acc | input | 1 | Host access to the data register this cycle |
| sts_acc | input | 1 | Host access to the main status register this cycle |
| drv_type | input | 2 | Attached drive type |
| shadow_q | output | 8 | Readable shadow copy of the register |
| rate_sel | output | 2 | Held rate field |
| density | output | 1 | Density-select level |
| mfm_rate | output | 3 | Decoded MFM bit-rate code |
| fm_rate | output | 3 | Decoded FM bit-rate code, 0 when none |
| precomp_units | output | 3 | Precompensation delay in unit steps |
| precomp_dflt | output | 1 | Default precompensation delay selected |
| sw_rst | output | 1 | One-cycle software-reset pulse |
| low_power | output | 1 | Manual low-power flag |

## Verification
A wrong held rate or code shows on the shadow byte and on the decoded rate, density and precompensation outputs. It appears in the cycle right after the write edge that should have set it. A wrong low-power state shows on `low_power` and on shadow bit 6 in the cycle after the write or access that should have changed it. A software-reset pulse that is missing or stretched shows up within one or two cycles. The drive-type dependence is combinational, so a wrong decode is visible as soon as `drv_type` changes.

// File: rtl/fdc_rate_pkg.sv
// Package: shared bit-rate codes and register field positions for the
// floppy rate control register. Assumes an 8-bit host data path.
package fdc_rate_pkg;

    localparam int REG_W    = 8;
    localparam int RATE_W   = 2;
    localparam int PC_W     = 3;
    localparam int RATE_LSB = 0;
    localparam int PC_LSB   = RATE_LSB + RATE_W;
    localparam int LP_BIT   = 6;
    localparam int SWR_BIT  = 7;

    typedef enum logic [2:0] {
        BR_NONE = 3'd0,
        BR_125K = 3'd1,
        BR_150K = 3'd2,
        BR_250K = 3'd3,
        BR_300K = 3'd4,
        BR_500K = 3'd5,
        BR_1M   = 3'd6,
        BR_2M   = 3'd7
    } bitrate_e;

endpackage

// File: rtl/fdc_rate_regs.sv
// Module: holds the rate field, the precompensation code and the low-power
// flag, and forms the registered software-reset pulse.
// Assumes: wr_en, dat_acc and sts_acc are single-cycle strobes in clk.
module fdc_rate_regs
    import fdc_rate_pkg::*;
#(
    parameter logic [RATE_W-1:0] RST_RATE = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              dat_acc,
    input  logic              sts_acc,
    output logic [RATE_W-1:0] rate_q,
    output logic [PC_W-1:0]   pc_q,
    output logic              lp_q,
    output logic              swrst_q
);

    logic sw_req;
    logic lp_exit;
    logic lp_enter;

    // Decode the write strobes into reset, exit and entry requests.
    always_comb begin
        sw_req   = wr_en && wr_data[SWR_BIT];
        lp_exit  = sw_req || dat_acc || sts_acc;
        lp_enter = wr_en && wr_data[LP_BIT];
    end

    // Rate and precompensation fields: hardware reset only; writes load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RST_RATE;
            pc_q   <= '0;
        end else if (wr_en) begin
            rate_q <= wr_data[RATE_LSB +: RATE_W];
            pc_q   <= wr_data[PC_LSB +: PC_W];
        end
    end

    // Low-power flag: exit by side effects wins over entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_q <= 1'b0;
        end else if (lp_exit) begin
            lp_q <= 1'b0;
        end else if (lp_enter) begin
            lp_q <= 1'b1;
        end
    end

    // Self-clearing software reset, one cycle per requesting write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swrst_q <= 1'b0;
        end else begin
            swrst_q <= sw_req;
        end
    end

endmodule

// File: rtl/fdc_rate_decode.sv
// Module: turns the held rate field and the drive type into MFM and FM
// bit-rate codes and the density level. Purely combinational.
// Assumes: drive type 11 behaves as drive type 00.
module fdc_rate_decode
    import fdc_rate_pkg::*;
(
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [1:0]        drv_type,
    output bitrate_e          mfm,
    output bitrate_e          fm,
    output logic              dens
);

    // Density depends only on the rate field.
    always_comb begin
        dens = (rate_sel == 2'b11) || (rate_sel == 2'b00);
    end

    // Bit-rate lookup; only rate field 01 depends on the drive type.
    always_comb begin
        unique case (rate_sel)
            2'b11: begin mfm = BR_1M;   fm = BR_NONE; end
            2'b00: begin mfm = BR_500K; fm = BR_250K; end
            2'b10: begin mfm = BR_250K; fm = BR_125K; end
            default: begin
                unique case (drv_type)
                    2'b01:   begin mfm = BR_500K; fm = BR_250K; end
                    2'b10:   begin mfm = BR_2M;   fm = BR_NONE; end
                    default: begin mfm = BR_300K; fm = BR_150K; end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/fdc_precomp_decode.sv
// Module: maps the precompensation code onto a unit-step count and a flag
// for the default delay. All-ones means zero delay; all-zeros the default.
// Assumes: the unit step size is chosen downstream from the bit rate.
module fdc_precomp_decode
    import fdc_rate_pkg::*;
(
    input  logic [PC_W-1:0] code,
    output logic [PC_W-1:0] units,
    output logic            dflt
);

    localparam logic [PC_W-1:0] ZERO_CODE = {PC_W{1'b1}};
    localparam logic [PC_W-1:0] DFLT_CODE = {PC_W{1'b0}};

    // Step count equals the code except for the two reserved extremes.
    always_comb begin
        dflt  = (code == DFLT_CODE);
        units = (code == ZERO_CODE || code == DFLT_CODE) ? '0 : code;
    end

endmodule

// File: rtl/fdc_rate_ctrl.sv
// Module: top of the floppy rate control register. Joins the held state,
// the rate decoder and the precompensation decoder, and builds the shadow.
// Assumes: synchronous active-low reset; shadow bits 5 and 7 read 0.
module fdc_rate_ctrl
    import fdc_rate_pkg::*;
#(
    parameter logic [1:0] RST_RATE = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       dat_acc,
    input  logic       sts_acc,
    input  logic [1:0] drv_type,
    output logic [7:0] shadow_q,
    output logic [1:0] rate_sel,
    output logic       density,
    output logic [2:0] mfm_rate,
    output logic [2:0] fm_rate,
    output logic [2:0] precomp_units,
    output logic       precomp_dflt,
    output logic       sw_rst,
    output logic       low_power
);

    logic [RATE_W-1:0] rate_q;
    logic [PC_W-1:0]   pc_q;
    logic              lp_q;
    logic              swrst_q;
    bitrate_e          mfm_e;
    bitrate_e          fm_e;

    fdc_rate_regs #(.RST_RATE(RST_RATE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dat_acc (dat_acc),
        .sts_acc (sts_acc),
        .rate_q  (rate_q),
        .pc_q    (pc_q),
        .lp_q    (lp_q),
        .swrst_q (swrst_q)
    );

    fdc_rate_decode u_dec (
        .rate_sel (rate_q),
        .drv_type (drv_type),
        .mfm      (mfm_e),
        .fm       (fm_e),
        .dens     (density)
    );

    fdc_precomp_decode u_pc (
        .code  (pc_q),
        .units (precomp_units),
        .dflt  (precomp_dflt)
    );

    // Shadow image and plain output wiring.
    always_comb begin
        shadow_q          = '0;
        shadow_q[RATE_LSB +: RATE_W] = rate_q;
        shadow_q[PC_LSB +: PC_W]     = pc_q;
        shadow_q[LP_BIT]  = lp_q;
        rate_sel          = rate_q;
        mfm_rate          = mfm_e;
        fm_rate           = fm_e;
        sw_rst            = swrst_q;
        low_power         = lp_q;
    end

endmodule

// File: rtl/fdc_rate_ctrl_chk.sv
// Module: assertion checker for fdc_rate_ctrl, bound to every instance.
// Assumes: it sees only the ports of the top module.
module fdc_rate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       dat_acc,
    input logic       sts_acc,
    input logic [1:0] drv_type,
    input logic [7:0] shadow_q,
    input logic [1:0] rate_sel,
    input logic       density,
    input logic [2:0] mfm_rate,
    input logic [2:0] fm_rate,
    input logic [2:0] precomp_units,
    input logic       precomp_dflt,
    input logic       sw_rst,
    input logic       low_power
);

    // R3: the pulse only follows a write with bit 7 set
    a_r3_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |-> $past(wr_en && wr_data[7]));

    // R3: every such write produces the pulse
    a_r3_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7]) |=> sw_rst);

    // R4: a plain low-power write sets the flag
    a_r4_lp_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6] && !wr_data[7] && !dat_acc && !sts_acc) |=> low_power);

    // R5: side-effect accesses leave low power
    a_r5_lp_exit_access: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc || sts_acc) |=> !low_power);

    // R6: software reset leaves low power
    a_r6_lp_exit_swrst: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7]) |=> !low_power);

    // R10: density agrees with the rate field seen in the shadow
    a_r10_density: assert property (@(posedge clk) disable iff (!rst_n)
        density == (shadow_q[1:0] == 2'b11 || shadow_q[1:0] == 2'b00));

    // R12: fields hold without a write
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(shadow_q[4:0]));

endmodule

bind fdc_rate_ctrl fdc_rate_ctrl_chk u_chk (.*);

// File: tb/fdc_rate_ctrl_bench.sv
`timescale 1ns/1ps
module fdc_rate_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       dat_acc = 1'b0;
    logic       sts_acc = 1'b0;
    logic [1:0] drv_type = '0;
    logic [7:0] shadow_q;
    logic [1:0] rate_sel;
    logic       density;
    logic [2:0] mfm_rate;
    logic [2:0] fm_rate;
    logic [2:0] precomp_units;
    logic       precomp_dflt;
    logic       sw_rst;
    logic       low_power;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fdc_rate_ctrl u_fdc_rate_ctrl (.*);

    // {drv_type, write byte, mfm, fm, density, units, default}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 8'h03, 3'd6, 3'd0, 1'b1, 3'd0, 1'b1},
        {2'd0, 8'h04, 3'd5, 3'd3, 1'b1, 3'd1, 1'b0},
        {2'd0, 8'h09, 3'd4, 3'd2, 1'b0, 3'd2, 1'b0},
        {2'd0, 8'h0E, 3'd3, 3'd1, 1'b0, 3'd3, 1'b0},
        {2'd1, 8'h11, 3'd5, 3'd3, 1'b0, 3'd4, 1'b0},
        {2'd2, 8'h15, 3'd7, 3'd0, 1'b0, 3'd5, 1'b0},
        {2'd3, 8'h19, 3'd4, 3'd2, 1'b0, 3'd6, 1'b0},
        {2'd1, 8'h1C, 3'd5, 3'd3, 1'b1, 3'd0, 1'b0},
        {2'd2, 8'h03, 3'd6, 3'd0, 1'b1, 3'd0, 1'b1},
        {2'd2, 8'h02, 3'd3, 3'd1, 1'b0, 3'd0, 1'b1},
        {2'd1, 8'h0A, 3'd3, 3'd1, 1'b0, 3'd2, 1'b0},
        {2'd2, 8'h00, 3'd5, 3'd3, 1'b1, 3'd0, 1'b1},
        {2'd0, 8'h2D, 3'd4, 3'd2, 1'b0, 3'd3, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write one byte; returns at the falling edge after the sampling edge.
    task automatic do_write(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic pulse_acc(input bit use_dat);
        @(negedge clk);
        dat_acc = use_dat;
        sts_acc = !use_dat;
        @(negedge clk);
        dat_acc = 1'b0;
        sts_acc = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: hardware reset state
        check("R1 shadow", shadow_q, 8'h02);
        check("R1 low_power", low_power, 0);
        check("R1 sw_rst", sw_rst, 0);
        check("R1 precomp default", precomp_dflt, 1);
        check("R7 reset mfm 250K", mfm_rate, 3);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            drv_type = VEC[i][20:19];
            do_write(VEC[i][18:11]);
            check("R2 shadow", shadow_q, {3'b000, VEC[i][15:11]});
            check("R7/R8 mfm", mfm_rate, VEC[i][10:8]);
            check("R9 fm", fm_rate, VEC[i][7:5]);
            check("R10 density", density, VEC[i][4]);
            check("R11 units", precomp_units, VEC[i][3:1]);
            check("R11 default", precomp_dflt, VEC[i][0]);
        end

        // R4: enter low power, then a write with bit 6 clear keeps it
        drv_type = 2'd0;
        do_write(8'h45);
        check("R4 enter", low_power, 1);
        check("R4 shadow bit6", shadow_q, 8'h45);
        do_write(8'h05);
        check("R4 bit6=0 keeps", low_power, 1);

        // R5: data-register access exits; R12 fields hold
        pulse_acc(1'b1);
        check("R5 data access exit", low_power, 0);
        check("R12 hold over access", shadow_q, 8'h05);
        repeat (3) @(negedge clk);
        check("R12 idle hold", shadow_q, 8'h05);

        // R5: status-register access exits
        do_write(8'h40);
        check("R4 enter again", low_power, 1);
        pulse_acc(1'b0);
        check("R5 status access exit", low_power, 0);

        // R5: access wins over a simultaneous set
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h40; dat_acc = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; dat_acc = 1'b0;
        check("R5 priority", low_power, 0);

        // R3 and R6: software reset pulse, leaves low power, keeps rate
        do_write(8'h40);
        do_write(8'hCD);
        check("R3 pulse high", sw_rst, 1);
        check("R6 swrst exits lp", low_power, 0);
        check("R3 fields written", shadow_q, 8'h0D);
        @(negedge clk);
        check("R3 pulse one cycle", sw_rst, 0);
        check("R3 rate not restored", rate_sel, 2'b01);

        // R1: hardware reset in mid-run
        do_write(8'h5D);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rerun shadow", shadow_q, 8'h02);
        check("R1 rerun lp", low_power, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule